// File: doc/BRIEF.md
# Rotating-Priority Bus Arbiter with Broken-Master Removal

This block arbitrates a shared 32-bit parallel bus among a small set of external bus masters (three by default). Each master asks for the bus on an active-low request line. The arbiter answers on an active-low grant line, and at most one grant is low at any time. The arbiter watches the bus frame and initiator-ready strobes, both active low. The bus counts as idle when both strobes are high. A master that now holds the grant starts its cycle at the next idle.

Fairness comes from a rotating priority. The master granted most recently drops to the lowest priority. When no enabled master is requesting, the grant stays parked on the last master that received it. A master can hold the grant on an idle bus while still requesting and yet start nothing. If this lasts sixteen consecutive clocks, the master is flagged as broken. It then takes no further part in arbitration until a re-enable pulse clears its flag. A global enable switches the whole arbiter off. A per-master enable decides whether that master's request is considered at all.

Top module: `pci_rr_arbiter`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge) all grants are high and all broken flags are clear. Master 0 has the highest priority, so if every master then requests, master 0 is granted one clock later.
- R2: At most one grant bit is low at any time. When the grant moves from one master to another, all grants are high for exactly one clock between the two.
- R3: Priority rotates. The search for the next winner starts at the index after the last granted master and wraps from N-1 to 0, so the last granted master has the lowest priority.
- R4: When no eligible request is present, the grant stays parked on the last granted master. Before the first grant after reset, nothing is parked and all grants stay high.
- R5: A master whose bit in mst_en_i is 0 is ignored: its request never wins, nobody parks on it, and if it holds the grant, the grant is withdrawn at the next clock.
- R6: While arb_en_i is 0, all grants are high one clock later. The broken flags keep their values.
- R7: If the granted master keeps requesting while the bus is idle (frame_n_i=1 and irdy_n_i=1) at 16 consecutive rising edges, then at the 16th edge its broken_o bit goes to 1 and its grant goes high.
- R8: The idle count restarts whenever the bus is busy, the grant changes, or the granted master is not requesting. A parked master that does not request is never flagged.
- R9: A master whose broken_o bit is set is never granted. The bit stays set until a one-clock pulse on its reenable_i bit clears it at the next edge.
- R10: The grant may move to another master while the bus is busy. The rotation and the one-clock gap still apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| arb_en_i | input | 1 | Global arbiter enable, 1 = on |
| req_n_i | input | N_MST | Bus requests, active low, bit i = master i |
| frame_n_i | input | 1 | Bus frame strobe, active low |
| irdy_n_i | input | 1 | Initiator-ready strobe, active low |
| mst_en_i | input | N_MST | Per-master request enable, 1 = considered |
| reenable_i | input | N_MST | Per-master pulse that clears the broken flag |
| gnt_n_o | output | N_MST | Bus grants, active low, registered |
| broken_o | output | N_MST | Per-master broken flag, 1 = removed from arbitration |

## Verification
The bench counts the idle window to the exact edge: 15 idle edges must leave the master in place and the 16th must remove it. A counter that is one off, or that forgets to restart after a busy stretch, fails one of the two checks. The bench also holds a master parked without a request for many idle clocks, which catches a design that wrongly flags masters that are idle but healthy. The handover gap and the wrap of the rotation are checked cycle by cycle. A design that switches grants back to back shows two grant changes with no all-high clock between them, and a design with the wrong priority order picks the wrong master. Further checks confirm that a disabled or broken master is never granted and is not parked on, and that only the re-enable pulse brings a broken master back.

// File: rtl/pci_arb_pkg.sv
// Shared types for the rotating-priority bus arbiter.
// Assumes: consumers import the package; no state lives here.
package pci_arb_pkg;

    // Action taken by the grant register at the next rising edge.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,   // keep the current grant (or no grant)
        ACT_DROP  = 2'd1,   // deassert all grants (handover gap, disable, removal)
        ACT_GRANT = 2'd2,   // grant the arbitration winner
        ACT_PARK  = 2'd3    // re-assert the grant on the last owner
    } arb_act_e;

endpackage

// File: rtl/arb_rot_pick.sv
// Rotating-priority picker.
// Finds the first eligible master, searching from the index after
// last_idx and wrapping from N_MST-1 back to 0, so that last_idx
// has the lowest priority. Purely combinational.
// Assumes: last_idx < N_MST.
module arb_rot_pick #(
    parameter int N_MST = 3,
    parameter int IDX_W = 2
) (
    input  logic [N_MST-1:0] elig,
    input  logic [IDX_W-1:0] last_idx,
    output logic             win_vld,
    output logic [IDX_W-1:0] win_idx
);

    // Walk the candidates in rotated order; keep the first hit.
    always_comb begin
        win_vld = 1'b0;
        win_idx = '0;
        for (int k = 1; k <= N_MST; k++) begin
            int cand;
            cand = int'(last_idx) + k;
            if (cand >= N_MST) cand = cand - N_MST;
            if (!win_vld && elig[cand]) begin
                win_vld = 1'b1;
                win_idx = IDX_W'(cand);
            end
        end
    end

endmodule

// File: rtl/arb_idle_timer.sv
// Idle watchdog for the granted master.
// Counts consecutive edges at which watch_en is high. hit is high
// during the cycle in which the TMO-th consecutive such edge
// occurs. The count restarts on hit or whenever watch_en is low.
// Assumes: TMO >= 2.
module arb_idle_timer #(
    parameter int TMO = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic watch_en,
    output logic hit
);
    localparam int CNT_W = $clog2(TMO + 1);

    logic [CNT_W-1:0] cnt_q;

    // The last counted edge is the one that reaches the limit.
    assign hit = watch_en && (cnt_q == CNT_W'(TMO - 1));

    // Advance, or restart on a gap or on the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (!watch_en || hit) cnt_q <= '0;
        else                       cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/arb_broken_flags.sv
// Per-master sticky broken flags.
// A set pulse raises the flag; a re-enable pulse clears it.
// If both arrive in the same cycle, the set wins.
// Assumes: set is one-hot or zero.
module arb_broken_flags #(
    parameter int N_MST = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_MST-1:0] set,
    input  logic [N_MST-1:0] clr,
    output logic [N_MST-1:0] flag
);

    for (genvar g = 0; g < N_MST; g++) begin : g_flag
        // One sticky bit per master.
        always_ff @(posedge clk) begin
            if (!rst_n)      flag[g] <= 1'b0;
            else if (set[g]) flag[g] <= 1'b1;
            else if (clr[g]) flag[g] <= 1'b0;
        end
    end

endmodule

// File: rtl/pci_rr_arbiter.sv
// Central rotating-priority bus arbiter (top).
// Grants one of N_MST masters at a time, inserts a one-clock gap on
// every handover, parks on the last owner, and removes a master that
// holds the grant while requesting on an idle bus for IDLE_TMO clocks.
// Assumes: all inputs are synchronous to clk; reset is synchronous
// and active low; grants are registered.
module pci_rr_arbiter #(
    parameter int N_MST    = 3,
    parameter int IDLE_TMO = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arb_en_i,
    input  logic [N_MST-1:0] req_n_i,
    input  logic             frame_n_i,
    input  logic             irdy_n_i,
    input  logic [N_MST-1:0] mst_en_i,
    input  logic [N_MST-1:0] reenable_i,
    output logic [N_MST-1:0] gnt_n_o,
    output logic [N_MST-1:0] broken_o
);
    import pci_arb_pkg::*;

    localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1;

    logic [IDX_W-1:0] cur_q;       // last granted master, lowest priority
    logic             parked_q;    // a grant has happened since reset
    logic [N_MST-1:0] gnt_q;       // active-high grant vector
    logic [N_MST-1:0] broken_q;
    logic [N_MST-1:0] elig;
    logic [N_MST-1:0] mark_set;
    logic             bus_idle;
    logic             park_ok;
    logic             cur_req;
    logic             watch_en;
    logic             tmo_hit;
    logic             win_vld;
    logic [IDX_W-1:0] win_idx;
    arb_act_e         act;

    // Eligible requests: asserted, enabled, not removed.
    assign elig     = ~req_n_i & mst_en_i & ~broken_q;
    assign bus_idle = frame_n_i & irdy_n_i;
    assign cur_req  = elig[cur_q];
    assign park_ok  = parked_q & mst_en_i[cur_q] & ~broken_q[cur_q];
    assign watch_en = arb_en_i & (|gnt_q) & bus_idle & cur_req;

    arb_rot_pick #(.N_MST(N_MST), .IDX_W(IDX_W)) u_pick (
        .elig     (elig),
        .last_idx (cur_q),
        .win_vld  (win_vld),
        .win_idx  (win_idx)
    );

    arb_idle_timer #(.TMO(IDLE_TMO)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .watch_en (watch_en),
        .hit      (tmo_hit)
    );

    // Flag the current owner when its idle window expires.
    always_comb begin
        mark_set = '0;
        if (tmo_hit) mark_set[cur_q] = 1'b1;
    end

    arb_broken_flags #(.N_MST(N_MST)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (mark_set),
        .clr   (reenable_i),
        .flag  (broken_q)
    );

    // Choose what the grant register does at the next edge.
    always_comb begin
        act = ACT_HOLD;
        if (!arb_en_i || tmo_hit) begin
            act = ACT_DROP;
        end else if (|gnt_q) begin
            if ((win_vld && (win_idx != cur_q)) || (!win_vld && !park_ok))
                act = ACT_DROP;
        end else if (win_vld) begin
            act = ACT_GRANT;
        end else if (park_ok) begin
            act = ACT_PARK;
        end
    end

    // Grant register, owner index and parking flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_q    <= '0;
            cur_q    <= IDX_W'(N_MST - 1);
            parked_q <= 1'b0;
        end else begin
            case (act)
                ACT_DROP: gnt_q <= '0;
                ACT_GRANT: begin
                    gnt_q          <= '0;
                    gnt_q[win_idx] <= 1'b1;
                    cur_q          <= win_idx;
                    parked_q       <= 1'b1;
                end
                ACT_PARK: begin
                    gnt_q        <= '0;
                    gnt_q[cur_q] <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign gnt_n_o  = ~gnt_q;
    assign broken_o = broken_q;

endmodule

// File: rtl/pci_rr_arbiter_chk.sv
// Assertion checker for pci_rr_arbiter, attached by bind below.
// Observes ports only.
module pci_rr_arbiter_chk #(
    parameter int N_MST = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             arb_en_i,
    input logic [N_MST-1:0] mst_en_i,
    input logic [N_MST-1:0] reenable_i,
    input logic [N_MST-1:0] gnt_n_o,
    input logic [N_MST-1:0] broken_o
);
    localparam logic [N_MST-1:0] ALL_HI = '1;

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (gnt_n_o == ALL_HI && broken_o == '0));  // R1

    AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~gnt_n_o) <= 1);  // R2

    AST_HANDOVER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_n_o != ALL_HI) |=> (gnt_n_o == ALL_HI || gnt_n_o == $past(gnt_n_o)));  // R2

    AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !arb_en_i |=> (gnt_n_o == ALL_HI));  // R6

    AST_NO_BROKEN_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (~gnt_n_o & broken_o) == '0);  // R9

    for (genvar g = 0; g < N_MST; g++) begin : g_mst
        AST_BROKEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (broken_o[g] && !reenable_i[g]) |=> broken_o[g]);  // R9

        AST_GRANT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
            !mst_en_i[g] |=> gnt_n_o[g]);  // R5
    end

endmodule

bind pci_rr_arbiter pci_rr_arbiter_chk #(.N_MST(N_MST)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .arb_en_i   (arb_en_i),
    .mst_en_i   (mst_en_i),
    .reenable_i (reenable_i),
    .gnt_n_o    (gnt_n_o),
    .broken_o   (broken_o)
);

// File: tb/pci_rr_arbiter_tb.sv
// Self-checking bench for pci_rr_arbiter: a vector table, then
// directed tests for reset, idle timeout and the corner cases.
module pci_rr_arbiter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 3;
    localparam int NVEC = 14;

    // Vector: {arb_en, mst_en[2:0], req_n[2:0], frame_n, irdy_n, exp_gnt_n[2:0]}
    localparam logic [11:0] VEC [NVEC] = '{
        12'b1_111_111_1_1_111,  // R4 nothing parked yet
        12'b1_111_110_1_1_110,  // R3 master 0 granted
        12'b1_111_111_1_1_110,  // R4 parked on master 0
        12'b1_111_100_1_1_111,  // R2 gap before master 1
        12'b1_111_100_1_1_101,  // R3 master 1 follows 0
        12'b1_111_010_1_1_111,  // R2 gap
        12'b1_111_010_1_1_011,  // R3 master 2 beats 0 after 1
        12'b1_111_000_1_1_111,  // R2 gap
        12'b1_111_000_1_1_110,  // R3 wrap to master 0
        12'b1_111_000_0_1_111,  // R10 handover while busy: gap
        12'b1_111_000_0_0_101,  // R10 master 1 granted during busy bus
        12'b1_011_011_1_1_101,  // R5 disabled master 2 ignored, park stays
        12'b0_011_011_1_1_111,  // R6 global disable
        12'b1_111_111_1_1_101   // R4 re-park on master 1
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         arb_en_i = 1'b1;
    logic [N-1:0] req_n_i = '1;
    logic         frame_n_i = 1'b1;
    logic         irdy_n_i = 1'b1;
    logic [N-1:0] mst_en_i = '1;
    logic [N-1:0] reenable_i = '0;
    logic [N-1:0] gnt_n_o;
    logic [N-1:0] broken_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    pci_rr_arbiter #(.N_MST(N), .IDLE_TMO(16)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .arb_en_i   (arb_en_i),
        .req_n_i    (req_n_i),
        .frame_n_i  (frame_n_i),
        .irdy_n_i   (irdy_n_i),
        .mst_en_i   (mst_en_i),
        .reenable_i (reenable_i),
        .gnt_n_o    (gnt_n_o),
        .broken_o   (broken_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // One edge, then sample a quarter period later.
    task automatic tick();
        @(posedge clk);
        #(CLK_PERIOD / 4);
    endtask

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; arb_en_i = 1'b1; req_n_i = '1; frame_n_i = 1'b1;
        irdy_n_i = 1'b1; mst_en_i = '1; reenable_i = '0;
        tick(); tick();
        check("R1 reset grants", gnt_n_o, 3'b111);
        check("R1 reset broken", broken_o, 3'b000);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD / 4);
        // Vector walk
        do_reset();
        for (int i = 0; i < NVEC; i++) begin
            {arb_en_i, mst_en_i, req_n_i, frame_n_i, irdy_n_i} = VEC[i][11:3];
            tick();
            check($sformatf("vector %0d (see R tag)", i), gnt_n_o, VEC[i][2:0]);
        end

        // R1: master 0 has top priority after reset
        do_reset();
        req_n_i = 3'b000; tick();
        check("R1 first winner", gnt_n_o, 3'b110);

        // R7 / R9: timeout, exclusion, re-enable
        do_reset();
        req_n_i = 3'b110; tick();
        check("R7 grant m0", gnt_n_o, 3'b110);
        repeat (15) tick();
        check("R7 not yet broken", broken_o, 3'b000);
        check("R7 grant held", gnt_n_o, 3'b110);
        tick();
        check("R7 broken set", broken_o, 3'b001);
        check("R7 grant dropped", gnt_n_o, 3'b111);
        repeat (3) tick();
        check("R9 broken excluded", gnt_n_o, 3'b111);
        req_n_i = 3'b100; tick();
        check("R9 other master served", gnt_n_o, 3'b101);
        req_n_i = 3'b110; reenable_i = 3'b001; tick();
        reenable_i = '0;
        check("R9 re-enable clears", broken_o, 3'b000);
        tick();
        check("R2 gap before m0 returns", gnt_n_o, 3'b111);
        tick();
        check("R9 m0 granted again", gnt_n_o, 3'b110);

        // R8: busy bus restarts the count
        do_reset();
        req_n_i = 3'b110; tick();
        repeat (10) tick();
        frame_n_i = 1'b0; repeat (3) tick();
        frame_n_i = 1'b1; repeat (15) tick();
        check("R8 restart after busy", broken_o, 3'b000);
        tick();
        check("R8 full window after busy", broken_o, 3'b001);

        // R8: parked master not requesting is never flagged
        do_reset();
        req_n_i = 3'b101; tick();
        req_n_i = 3'b111; repeat (40) tick();
        check("R8 parked idle grant", gnt_n_o, 3'b101);
        check("R8 parked not broken", broken_o, 3'b000);

        // R5: disabling the parked owner withdraws the grant
        mst_en_i = 3'b101; tick();
        check("R5 disabled owner dropped", gnt_n_o, 3'b111);
        tick();
        check("R5 no park on disabled", gnt_n_o, 3'b111);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule